// File: doc/BRIEF.md
# Multiply High/Low Pair Fusion Unit

The unit looks at a window of two adjacent 32-bit instructions together with the values of the two source registers of the first one. When the first instruction is a high-half multiply (signed by signed, signed by unsigned, or unsigned by unsigned) and the second is a plain low-half multiply on the same sources, it runs the pair as one operation. A single multiply produces a 64-bit product. The upper word is written to the destination of the first instruction and the lower word to the destination of the second.

When no pair is found, only the first slot is executed, on the same multiplier, and the second slot is left for a later window. A consumed-count output tells the front end how far to advance: two, one or zero instructions. All results, write enables, the fused flag and the count are registered, so they appear one clock after the window is presented.

Top module: `mpf_pair_fuse`

## Requirements
- R1: While rst_ni is low, every output is zero: both write enables, both addresses, both data words, fused_o and consumed_o.
- R2: A word counts as a multiply only when bits 1:0 are 11, bits 6:0 are 0110011, bits 31:25 are 0000001 and bit 14 is 0. Bits 13:12 then select the operation: 00 low word, 01 high word signed by signed, 10 high word signed rs1 by unsigned rs2, 11 high word unsigned by unsigned. The destination is bits 11:7, rs1 is bits 19:15 and rs2 is bits 24:20.
- R3: Without fusion, a valid multiply in slot 0 writes one result on port 0, at its destination: the low 32 bits of the product for the low operation, otherwise the upper 32 bits with the signedness of its operation. A valid non-multiply in slot 0 writes nothing. Port 1 stays disabled.
- R4: Fusion needs both slots valid, slot 0 a high-half multiply, slot 1 a low-half multiply, equal rs1 fields and equal rs2 fields.
- R5: A pair whose slot-0 destination equals its rs1 or its rs2 is not fused.
- R6: A pair whose two destinations are equal is not fused.
- R7: A fused pair writes the upper product word on port 0 at the slot-0 destination and the lower word on port 1 at the slot-1 destination. The product uses the signedness of the slot-0 operation, and fused_o is 1.
- R8: A low-half multiply followed by a high-half multiply is not fused, whatever its fields.
- R9: No write enable is ever raised for register 0, fused or not. In a fused pair the other destination is still written.
- R10: consumed_o is 2 for a fused pair, 1 when slot 0 is valid and not fused, and 0 when slot 0 is invalid, whatever slot 1 holds.
- R11: Every output reflects the window presented on the preceding clock edge. A window with slot 0 invalid produces no write in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn0_i | input | 32 | Instruction word in slot 0 (older) |
| insn0_valid_i | input | 1 | Slot 0 holds an instruction |
| insn1_i | input | 32 | Instruction word in slot 1 (younger) |
| insn1_valid_i | input | 1 | Slot 1 holds an instruction |
| rs1_val_i | input | 32 | Value of slot 0 rs1 |
| rs2_val_i | input | 32 | Value of slot 0 rs2 |
| wb0_en_o | output | 1 | Write enable, port 0 |
| wb0_addr_o | output | 5 | Destination register, port 0 |
| wb0_data_o | output | 32 | Write data, port 0 |
| wb1_en_o | output | 1 | Write enable, port 1 (fused low word) |
| wb1_addr_o | output | 5 | Destination register, port 1 |
| wb1_data_o | output | 32 | Write data, port 1 |
| fused_o | output | 1 | The previous window was fused |
| consumed_o | output | 2 | Instructions taken from the previous window |

## Verification
On every cycle the assertions check the structural rules of fusion: no write to register 0, a port-1 write only with fusion, a count of 2 exactly when fused, equal sources and a destination clear of the sources one cycle after every fused result, distinct enabled addresses, and an idle result after an invalid slot 0. Which product word lands where and with which signedness, and the decline of pairs that break the order, the matching or the encoding, can only be shown by the bench's scenarios. The bench compares each of these against its own behavioural model on every clock, using directed corner cases and a long random stream biased toward near-miss pairs.

// File: rtl/mpf_pkg.sv
`timescale 1ns/1ps
package mpf_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned REG_AW = 5;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;
  localparam logic [6:0] F7_MULDIV   = 7'b0000001;

  // operation select from insn[13:12] when insn[14] is clear
  typedef enum logic [1:0] {
    MF_LO  = 2'b00,
    MF_HSS = 2'b01,
    MF_HSU = 2'b10,
    MF_HUU = 2'b11
  } mul_fn_e;

  typedef struct packed {
    logic              is_mul;
    mul_fn_e           fn;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } slot_dec_t;
endpackage

// File: rtl/mpf_slot_decode.sv
`timescale 1ns/1ps
module mpf_slot_decode
  import mpf_pkg::*;
(
  input  logic [ILEN-1:0] insn_i,
  input  logic            valid_i,
  output slot_dec_t       dec_o
);
  logic len_ok, opc_ok, f7_ok;

  always_comb begin
    len_ok = (insn_i[1:0] == 2'b11);
    opc_ok = (insn_i[6:0] == OPC_REG_REG);
    f7_ok  = (insn_i[31:25] == F7_MULDIV);
    dec_o.is_mul = valid_i && len_ok && opc_ok && f7_ok && !insn_i[14];
    dec_o.fn     = mul_fn_e'(insn_i[13:12]);
    dec_o.rd     = insn_i[11:7];
    dec_o.rs1    = insn_i[19:15];
    dec_o.rs2    = insn_i[24:20];
  end
endmodule

// File: rtl/mpf_pair_match.sv
`timescale 1ns/1ps
module mpf_pair_match
  import mpf_pkg::*;
(
  input  slot_dec_t hi_i,
  input  slot_dec_t lo_i,
  output logic      fuse_o
);
  logic kinds_ok, srcs_ok, dst_clear, dst_distinct;

  always_comb begin
    kinds_ok     = hi_i.is_mul && lo_i.is_mul && (hi_i.fn != MF_LO) && (lo_i.fn == MF_LO);
    srcs_ok      = (hi_i.rs1 == lo_i.rs1) && (hi_i.rs2 == lo_i.rs2);
    dst_clear    = (hi_i.rd != hi_i.rs1) && (hi_i.rd != hi_i.rs2);
    dst_distinct = (lo_i.rd != hi_i.rd);
    fuse_o       = kinds_ok && srcs_ok && dst_clear && dst_distinct;
  end
endmodule

// File: rtl/mpf_mul_core.sv
`timescale 1ns/1ps
module mpf_mul_core #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  output logic [2*XLEN-1:0] prod_o
);
  logic [2*XLEN-1:0] a_ext, b_ext;

  // product modulo 2^(2*XLEN) of extended operands is exact for all variants
  always_comb begin
    a_ext  = {{XLEN{a_signed_i & a_i[XLEN-1]}}, a_i};
    b_ext  = {{XLEN{b_signed_i & b_i[XLEN-1]}}, b_i};
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/mpf_pair_fuse.sv
`timescale 1ns/1ps
module mpf_pair_fuse
  import mpf_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ILEN-1:0]   insn0_i,
  input  logic              insn0_valid_i,
  input  logic [ILEN-1:0]   insn1_i,
  input  logic              insn1_valid_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [XLEN-1:0]   rs2_val_i,
  output logic              wb0_en_o,
  output logic [REG_AW-1:0] wb0_addr_o,
  output logic [XLEN-1:0]   wb0_data_o,
  output logic              wb1_en_o,
  output logic [REG_AW-1:0] wb1_addr_o,
  output logic [XLEN-1:0]   wb1_data_o,
  output logic              fused_o,
  output logic [1:0]        consumed_o
);
  localparam int unsigned NSLOT = 2;
  localparam int unsigned PW    = 2 * XLEN;

  logic [NSLOT-1:0][ILEN-1:0] insn_w;
  logic [NSLOT-1:0]           vld_w;
  slot_dec_t                  dec [NSLOT];

  assign insn_w = {insn1_i, insn0_i};
  assign vld_w  = {insn1_valid_i, insn0_valid_i};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    mpf_slot_decode u_dec (
      .insn_i (insn_w[g]),
      .valid_i(vld_w[g]),
      .dec_o  (dec[g])
    );
  end

  logic fuse;
  mpf_pair_match u_match (
    .hi_i  (dec[0]),
    .lo_i  (dec[1]),
    .fuse_o(fuse)
  );

  logic          a_sgn, b_sgn;
  logic [PW-1:0] prod;
  logic [XLEN-1:0] prod_hi, prod_lo;

  assign a_sgn   = (dec[0].fn == MF_HSS) || (dec[0].fn == MF_HSU);
  assign b_sgn   = (dec[0].fn == MF_HSS);
  assign prod_hi = prod[PW-1:XLEN];
  assign prod_lo = prod[XLEN-1:0];

  mpf_mul_core #(.XLEN(XLEN)) u_mul (
    .a_i       (rs1_val_i),
    .b_i       (rs2_val_i),
    .a_signed_i(a_sgn),
    .b_signed_i(b_sgn),
    .prod_o    (prod)
  );

  logic              n_w0_en, n_w1_en;
  logic [REG_AW-1:0] n_w0_addr, n_w1_addr;
  logic [XLEN-1:0]   n_w0_data, n_w1_data;
  logic [1:0]        n_cnt;

  always_comb begin
    n_w0_en   = 1'b0;
    n_w0_addr = '0;
    n_w0_data = '0;
    n_w1_en   = 1'b0;
    n_w1_addr = '0;
    n_w1_data = '0;
    n_cnt     = 2'd0;
    if (fuse) begin
      n_cnt     = 2'd2;
      n_w0_en   = (dec[0].rd != '0);
      n_w0_addr = dec[0].rd;
      n_w0_data = prod_hi;
      n_w1_en   = (dec[1].rd != '0);
      n_w1_addr = dec[1].rd;
      n_w1_data = prod_lo;
    end else if (insn0_valid_i) begin
      n_cnt = 2'd1;
      if (dec[0].is_mul) begin
        n_w0_en   = (dec[0].rd != '0);
        n_w0_addr = dec[0].rd;
        n_w0_data = (dec[0].fn == MF_LO) ? prod_lo : prod_hi;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb0_en_o   <= 1'b0;
      wb0_addr_o <= '0;
      wb0_data_o <= '0;
      wb1_en_o   <= 1'b0;
      wb1_addr_o <= '0;
      wb1_data_o <= '0;
      fused_o    <= 1'b0;
      consumed_o <= 2'd0;
    end else begin
      wb0_en_o   <= n_w0_en;
      wb0_addr_o <= n_w0_addr;
      wb0_data_o <= n_w0_data;
      wb1_en_o   <= n_w1_en;
      wb1_addr_o <= n_w1_addr;
      wb1_data_o <= n_w1_data;
      fused_o    <= fuse;
      consumed_o <= n_cnt;
    end
  end
endmodule

// File: rtl/mpf_checker.sv
`timescale 1ns/1ps
module mpf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       v0_i,
  input logic [4:0] rd0_i,
  input logic [4:0] rs1_0_i,
  input logic [4:0] rs2_0_i,
  input logic [4:0] rs1_1_i,
  input logic [4:0] rs2_1_i,
  input logic       wb0_en_i,
  input logic [4:0] wb0_addr_i,
  input logic       wb1_en_i,
  input logic [4:0] wb1_addr_i,
  input logic       fused_i,
  input logic [1:0] consumed_i
);
  assert_no_x0_port0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb0_en_i |-> wb0_addr_i != 5'd0);
  assert_no_x0_port1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb1_en_i |-> wb1_addr_i != 5'd0);
  assert_port1_only_fused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb1_en_i |-> fused_i);
  assert_count_fused_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fused_i |-> consumed_i == 2'd2);
  assert_count_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fused_i |-> consumed_i != 2'd2);
  assert_idle_next_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v0_i |=> (consumed_i == 2'd0) && !wb0_en_i && !wb1_en_i);
  assert_valid_next_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v0_i |=> consumed_i != 2'd0);
  assert_same_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fused_i |-> ($past(rs1_0_i) == $past(rs1_1_i)) && ($past(rs2_0_i) == $past(rs2_1_i)));
  assert_rdh_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fused_i |-> ($past(rd0_i) != $past(rs1_0_i)) && ($past(rd0_i) != $past(rs2_0_i)));
  assert_dest_distinct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fused_i && wb0_en_i && wb1_en_i) |-> wb0_addr_i != wb1_addr_i);
endmodule

bind mpf_pair_fuse mpf_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .v0_i      (insn0_valid_i),
  .rd0_i     (insn0_i[11:7]),
  .rs1_0_i   (insn0_i[19:15]),
  .rs2_0_i   (insn0_i[24:20]),
  .rs1_1_i   (insn1_i[19:15]),
  .rs2_1_i   (insn1_i[24:20]),
  .wb0_en_i  (wb0_en_o),
  .wb0_addr_i(wb0_addr_o),
  .wb1_en_i  (wb1_en_o),
  .wb1_addr_i(wb1_addr_o),
  .fused_i   (fused_o),
  .consumed_i(consumed_o)
);

// File: tb/sim_mpf_pair_fuse.sv
`timescale 1ns/1ps
module sim_mpf_pair_fuse;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn0_i = '0, insn1_i = '0;
  logic        insn0_valid_i = 1'b0, insn1_valid_i = 1'b0;
  logic [31:0] rs1_val_i = '0, rs2_val_i = '0;
  logic        wb0_en_o, wb1_en_o, fused_o;
  logic [4:0]  wb0_addr_o, wb1_addr_o;
  logic [31:0] wb0_data_o, wb1_data_o;
  logic [1:0]  consumed_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  mpf_pair_fuse u0 (.*);

  function automatic logic [31:0] mk(input logic [2:0] f3, input int rd, input int s1, input int s2);
    return {7'b0000001, 5'(s2), 5'(s1), f3, 5'(rd), 7'b0110011};
  endfunction

  function automatic bit model_is_mul(input logic [31:0] w);
    return (w[1:0] == 2'b11) && (w[6:0] == 7'b0110011) && (w[31:25] == 7'b0000001) && (w[14] == 1'b0);
  endfunction

  function automatic logic [63:0] model_prod(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ax, bx;
    ax = (op == 2'd1 || op == 2'd2) ? {{32{a[31]}}, a} : {32'd0, a};
    bx = (op == 2'd1) ? {{32{b[31]}}, b} : {32'd0, b};
    return ax * bx;
  endfunction

  task automatic check_reset();
    n_chk++;
    if (wb0_en_o || wb1_en_o || fused_o || consumed_o != 0 || wb0_addr_o != 0 ||
        wb1_addr_o != 0 || wb0_data_o != 0 || wb1_data_o != 0) begin
      n_fail++;
      $display("FAIL R1: outputs in reset en=%b/%b f=%b c=%0d d=%h/%h, expected all zero",
               wb0_en_o, wb1_en_o, fused_o, consumed_o, wb0_data_o, wb1_data_o);
    end
  endtask

  // presents one window at a negedge and checks the registered result one edge later
  task automatic step(input logic [31:0] i0, input logic v0, input logic [31:0] i1, input logic v1,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    bit m0, m1, fz, e0, e1;
    logic [4:0] a0, a1;
    logic [31:0] d0, d1;
    logic [63:0] p;
    int c;
    insn0_i = i0; insn0_valid_i = v0; insn1_i = i1; insn1_valid_i = v1;
    rs1_val_i = a; rs2_val_i = b;
    m0 = v0 && model_is_mul(i0);
    m1 = v1 && model_is_mul(i1);
    fz = m0 && m1 && i0[13:12] != 2'd0 && i1[13:12] == 2'd0 &&
         i0[19:15] == i1[19:15] && i0[24:20] == i1[24:20] &&
         i0[11:7] != i0[19:15] && i0[11:7] != i0[24:20] && i0[11:7] != i1[11:7];
    p = model_prod(i0[13:12], a, b);
    e0 = 0; e1 = 0; a0 = i0[11:7]; a1 = i1[11:7]; d0 = 0; d1 = 0; c = 0;
    if (fz) begin
      c = 2; e0 = (a0 != 0); d0 = p[63:32]; e1 = (a1 != 0); d1 = p[31:0];
    end else if (v0) begin
      c = 1;
      if (m0) begin
        e0 = (a0 != 0);
        d0 = (i0[13:12] == 2'd0) ? p[31:0] : p[63:32];
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    n_chk++;
    if (wb0_en_o !== e0 || wb1_en_o !== e1 || fused_o !== fz || consumed_o !== 2'(c) ||
        (e0 && (wb0_addr_o !== a0 || wb0_data_o !== d0)) ||
        (e1 && (wb1_addr_o !== a1 || wb1_data_o !== d1))) begin
      n_fail++;
      $display("FAIL %s: act en=%b/%b a=%0d/%0d d=%h/%h f=%b c=%0d exp en=%b/%b a=%0d/%0d d=%h/%h f=%b c=%0d",
               tag, wb0_en_o, wb1_en_o, wb0_addr_o, wb1_addr_o, wb0_data_o, wb1_data_o, fused_o,
               consumed_o, e0, e1, a0, a1, d0, d1, fz, c);
    end
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    check_reset();                       // R1
    rst_ni = 1'b1;
    step('0, 0, '0, 0, 32'h5, 32'h7, "R11 idle window");
    // single operations, R2 / R3
    step(mk(3'b000, 5, 1, 2), 1, '0, 0, 32'hFFFF_FFFE, 32'h0000_0003, "R3 single low");
    step(mk(3'b001, 6, 1, 2), 1, '0, 0, 32'hFFFF_FFFE, 32'h0000_0003, "R3 single high ss");
    step(mk(3'b010, 6, 1, 2), 1, '0, 0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R3 single high su");
    step(mk(3'b011, 6, 1, 2), 1, '0, 0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R3 single high uu");
    step(32'h0000_0013, 1, mk(3'b000, 7, 1, 2), 1, 32'h3, 32'h4, "R3 non-multiply slot0");
    // fused pairs, R4 / R7
    step(mk(3'b001, 10, 1, 2), 1, mk(3'b000, 11, 1, 2), 1, 32'h8000_0000, 32'hFFFF_FFFF, "R7 fused ss");
    step(mk(3'b010, 10, 3, 4), 1, mk(3'b000, 11, 3, 4), 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 fused su");
    step(mk(3'b011, 12, 3, 4), 1, mk(3'b000, 13, 3, 4), 1, 32'hDEAD_BEEF, 32'h1234_5678, "R7 fused uu");
    step(mk(3'b001, 10, 1, 2), 1, mk(3'b000, 11, 2, 1), 1, 32'h9, 32'hA, "R4 swapped sources");
    step(mk(3'b001, 10, 1, 2), 1, mk(3'b000, 11, 1, 2), 0, 32'h9, 32'hA, "R4 slot1 invalid");
    step(mk(3'b001, 10, 1, 2), 1, mk(3'b001, 11, 1, 2), 1, 32'h9, 32'hA, "R4 both high");
    // destination rules
    step(mk(3'b001, 1, 1, 2), 1, mk(3'b000, 11, 1, 2), 1, 32'h8000_0001, 32'h7, "R5 rdh equals rs1");
    step(mk(3'b011, 2, 1, 2), 1, mk(3'b000, 11, 1, 2), 1, 32'h8000_0001, 32'h7, "R5 rdh equals rs2");
    step(mk(3'b001, 9, 1, 2), 1, mk(3'b000, 9, 1, 2), 1, 32'h8000_0001, 32'h7, "R6 equal destinations");
    step(mk(3'b000, 11, 1, 2), 1, mk(3'b001, 10, 1, 2), 1, 32'h8000_0001, 32'h7, "R8 reversed order");
    step(mk(3'b001, 0, 1, 2), 1, mk(3'b000, 11, 1, 2), 1, 32'hF000_0000, 32'h10, "R9 fused rdh x0");
    step(mk(3'b011, 12, 1, 2), 1, mk(3'b000, 0, 1, 2), 1, 32'hF000_0000, 32'h10, "R9 fused rdl x0");
    step(mk(3'b000, 0, 1, 2), 1, '0, 0, 32'h3, 32'h5, "R9 single x0");
    // encoding rules
    step(mk(3'b001, 10, 1, 2), 1, mk(3'b000, 11, 1, 2) & 32'hFFFF_FFFC, 1, 32'h3, 32'h5, "R2 slot1 low bits");
    step(mk(3'b001, 10, 1, 2) & 32'hFFFF_FFFE, 1, mk(3'b000, 11, 1, 2), 1, 32'h3, 32'h5, "R2 slot0 low bits");
    step(mk(3'b100, 10, 1, 2), 1, mk(3'b000, 11, 1, 2), 1, 32'h3, 32'h5, "R2 divide funct3");
    step(mk(3'b001, 10, 1, 2) ^ 32'h4000_0000, 1, mk(3'b000, 11, 1, 2), 1, 32'h3, 32'h5, "R2 funct7");
    step('0, 0, mk(3'b000, 11, 1, 2), 1, 32'h3, 32'h5, "R10 slot0 invalid");
    // random stream biased toward near-miss pairs
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] w0, w1, a, b;
      logic [2:0] f0, f1;
      f0 = 3'($urandom_range(0, 4));
      f1 = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 4)) : 3'b000;
      w0 = mk(f0, $urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 3));
      w1 = mk(f1, $urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) w1[1:0] = 2'($urandom_range(0, 2));
      case ($urandom_range(0, 3))
        0: a = 32'h8000_0000;
        1: a = 32'hFFFF_FFFF;
        default: a = $urandom;
      endcase
      b = ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFFF : $urandom;
      step(w0, $urandom_range(0, 7) != 0, w1, $urandom_range(0, 7) != 0, a, b, "R11 random stream");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule